// File: doc/BRIEF.md
# Event Permit Filter

This block keeps one permit bit per event number and answers two kinds of question about it. A single-event lookup returns, one cycle after the request, whether that event may be counted. A capability query takes a 64-bit word of event-support flags, masks it with the permit bits, and returns the result one cycle later. The lower 32 bits cover a 32-event group near the bottom of the event space. The upper 32 bits cover the same group in a second bank that sits a fixed offset higher.

The permit bits are programmed by range commands. Each command carries a base event, a count and an action code, which is either allow or deny. An accepted command is applied one entry per clock while a busy output is high. The first accepted command after reset also sets what every entry that is never written reads as. If that first command is an allow, unwritten entries read as denied. If it is a deny, unwritten entries read as permitted. Until a command has been accepted, every event is permitted.

A run-lock input freezes the contents once the system is running. A reset returns the block to its unprogrammed state.

Top module: `event_permit_filter`

## Requirements
- R1: After reset, with no command accepted, every lookup returns permitted and a capability query returns its input word unchanged in all 64 bits.
- R2: If the first accepted command is an allow (action code 2'b01), every entry outside its range reads as denied, and entries base to base+count-1 read as permitted.
- R3: If the first accepted command is a deny (action code 2'b10), every entry outside its range reads as permitted, and entries base to base+count-1 read as denied.
- R4: A later allow sets, and a later deny clears, exactly the entries from base to base+count-1. The default chosen by the first command does not change.
- R5: A command whose base+count exceeds the number of events is rejected with a one-cycle `rsp_bad` pulse and changes no entry. A range that ends exactly at the last event is accepted.
- R6: A command whose action code is 2'b00 or 2'b11 is rejected with `rsp_bad` and changes no entry.
- R7: While `run_lock` is high, a command that is otherwise valid is rejected with a one-cycle `rsp_locked` pulse and changes no entry. A command with a bad range or a bad action code still reports `rsp_bad`.
- R8: An accepted command holds `cmd_busy` high for count+1 cycles, starting the cycle after it is presented, and writes one entry per cycle. `cmd_done` pulses in the cycle after `cmd_busy` falls. Commands presented while busy are ignored.
- R9: `lk_valid` is high exactly one cycle after `lk_req`, and `lk_permit` then holds the permit bit of the requested event.
- R10: In a capability query, output bit i of the lower half is input bit i AND the permit bit of event 32*grp+i. Group 0 covers events 0 to 31 and group 1 covers events 32 to 63. The result arrives with `cap_valid` one cycle after `cap_req`.
- R11: Output bit 32+i of a capability query is input bit 32+i AND the permit bit of event HI_BANK+32*grp+i, when that event lies in the event space. Otherwise the bit reads 0 once the filter is programmed.
- R12: Asserting reset after programming returns the block to the unprogrammed state of R1.
- R13: A first command with count 0 is accepted. It writes no entry but fixes the default, so after a zero-count allow every event reads as denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_lock | input | 1 | High once the system runs; rejects new commands |
| cmd_valid | input | 1 | Range command presented this cycle |
| cmd_base | input | EVT_BITS+1 | First event of the range |
| cmd_count | input | EVT_BITS+1 | Number of events in the range |
| cmd_action | input | 2 | 2'b01 allow, 2'b10 deny, others invalid |
| cmd_busy | output | 1 | Range write in progress |
| cmd_done | output | 1 | One-cycle pulse when a range write finishes |
| rsp_bad | output | 1 | One-cycle pulse: command rejected for range or action |
| rsp_locked | output | 1 | One-cycle pulse: command rejected because of the lock |
| lk_req | input | 1 | Lookup request |
| lk_event | input | EVT_BITS | Event number to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_permit | output | 1 | 1 when the looked-up event is permitted |
| cap_req | input | 1 | Capability query request |
| cap_grp | input | 1 | Selects event group 0 (events 0-31) or 1 (events 32-63) |
| cap_in | input | 64 | Capability word to be masked |
| cap_valid | output | 1 | Capability result valid |
| cap_out | output | 64 | Masked capability word |

## Verification
The hardest case to reach is the upper half of the capability word. It depends on permit bits thousands of events above the group being queried, so the bench builds the filter with an event space large enough to include that bank. It then writes a single entry inside the bank and checks that exactly one upper bit survives while the lower half still reflects earlier ranges. The default polarity set by the first command can only be seen after a reset, so the bench resets between scenarios. It starts each one with an allow, a deny, or a zero-count command, then probes entries just outside the written range. The lock, bad-range and bad-action cases are followed at once by lookups of the entries the rejected command named.

// File: rtl/epf_pkg.sv
// Package epf_pkg
// Shared encodings for the event permit filter: command action codes,
// the range-walk state and the capability word geometry.
// Assumes: action codes are fixed by the command producer.
package epf_pkg;

    localparam int CAP_GRP_W = 32;
    localparam int CAP_W     = 2 * CAP_GRP_W;
    localparam int CAP_GRPS  = 2;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_ALLOW = 2'b01,
        ACT_DENY  = 2'b10,
        ACT_RSVD  = 2'b11
    } epf_action_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } epf_walk_e;

endpackage

// File: rtl/epf_cmd_walker.sv
// Module epf_cmd_walker
// Checks incoming range commands and rejects them for a bad range, a bad
// action or the run lock. Accepted ranges are walked one entry per cycle
// and turned into single-bit writes. This module also owns the
// "programmed" flag and the default polarity that the first accepted
// command decides.
// Assumes: commands that arrive while a walk is in progress are dropped.
module epf_cmd_walker
    import epf_pkg::*;
#(
    parameter int EVT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_lock,
    input  logic                cmd_valid,
    input  logic [EVT_BITS:0]   cmd_base,
    input  logic [EVT_BITS:0]   cmd_count,
    input  logic [1:0]          cmd_action,
    output logic                cmd_busy,
    output logic                cmd_done,
    output logic                rsp_bad,
    output logic                rsp_locked,
    output logic                programmed,
    output logic                invert,
    output logic                wr_en,
    output logic [EVT_BITS-1:0] wr_idx,
    output logic                wr_val
);

    localparam int LEN_W   = EVT_BITS + 1;
    localparam int SUM_W   = LEN_W + 1;
    localparam int NUM_EVT = 1 << EVT_BITS;
    localparam logic [SUM_W-1:0] SPACE = SUM_W'(NUM_EVT);

    epf_walk_e             state_q;
    logic [EVT_BITS-1:0]   ptr_q;
    logic [LEN_W-1:0]      remain_q;
    logic                  val_q;
    logic [SUM_W-1:0]      end_sum;
    logic                  range_ok;
    logic                  act_ok;
    logic                  is_deny;

    // Decode the validity of the command presented this cycle.
    always_comb begin
        end_sum  = {1'b0, cmd_base} + {1'b0, cmd_count};
        range_ok = (end_sum <= SPACE);
        is_deny  = (cmd_action == ACT_DENY);
        act_ok   = (cmd_action == ACT_ALLOW) || is_deny;
    end

    // Accept or reject commands, then step through the accepted range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WALK_IDLE;
            ptr_q      <= '0;
            remain_q   <= '0;
            val_q      <= 1'b0;
            programmed <= 1'b0;
            invert     <= 1'b0;
            rsp_bad    <= 1'b0;
            rsp_locked <= 1'b0;
            cmd_done   <= 1'b0;
        end else begin
            rsp_bad    <= 1'b0;
            rsp_locked <= 1'b0;
            cmd_done   <= 1'b0;
            case (state_q)
                WALK_IDLE: begin
                    if (cmd_valid) begin
                        if (!range_ok || !act_ok) begin
                            rsp_bad <= 1'b1;
                        end else if (run_lock) begin
                            rsp_locked <= 1'b1;
                        end else begin
                            state_q  <= WALK_RUN;
                            ptr_q    <= cmd_base[EVT_BITS-1:0];
                            remain_q <= cmd_count;
                            val_q    <= !is_deny;
                            if (!programmed) begin
                                programmed <= 1'b1;
                                invert     <= is_deny;
                            end
                        end
                    end
                end
                WALK_RUN: begin
                    if (remain_q == '0) begin
                        state_q  <= WALK_IDLE;
                        cmd_done <= 1'b1;
                    end else begin
                        ptr_q    <= ptr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // Drive the single-entry write port while entries remain.
    always_comb begin
        cmd_busy = (state_q == WALK_RUN);
        wr_en    = cmd_busy && (remain_q != '0);
        wr_idx   = ptr_q;
        wr_val   = val_q;
    end

endmodule

// File: rtl/epf_bit_store.sv
// Module epf_bit_store
// Holds one stored bit per event. The effective permit bit is the stored
// bit XOR the default polarity, so choosing a default needs no fill pass.
// Serves the registered single-event lookup and exposes the permit bits
// of both capability groups and their upper banks.
// Assumes: the event space holds at least 64 events.
module epf_bit_store
    import epf_pkg::*;
#(
    parameter int EVT_BITS = 10,
    parameter int HI_BANK  = 16384
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                programmed,
    input  logic                invert,
    input  logic                wr_en,
    input  logic [EVT_BITS-1:0] wr_idx,
    input  logic                wr_val,
    input  logic                lk_req,
    input  logic [EVT_BITS-1:0] lk_event,
    output logic                lk_valid,
    output logic                lk_permit,
    output logic [CAP_GRPS-1:0][CAP_GRP_W-1:0] grp_lo,
    output logic [CAP_GRPS-1:0][CAP_GRP_W-1:0] grp_hi
);

    localparam int NUM_EVT = 1 << EVT_BITS;

    logic [NUM_EVT-1:0] bits_q;

    // Store entries relative to the default polarity; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_val ^ invert;
        end
    end

    // Answer a lookup one cycle after it is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid  <= 1'b0;
            lk_permit <= 1'b0;
        end else begin
            lk_valid <= lk_req;
            if (lk_req) begin
                lk_permit <= programmed ? (bits_q[lk_event] ^ invert) : 1'b1;
            end
        end
    end

    // Tap the permit bits of each capability group and its upper bank.
    for (genvar g = 0; g < CAP_GRPS; g++) begin : g_grp
        localparam int LO_BASE = g * CAP_GRP_W;
        localparam int HI_BASE = HI_BANK + g * CAP_GRP_W;
        for (genvar i = 0; i < CAP_GRP_W; i++) begin : g_bit
            assign grp_lo[g][i] = programmed ? (bits_q[LO_BASE + i] ^ invert) : 1'b1;
        end
        if (HI_BASE + CAP_GRP_W <= NUM_EVT) begin : g_hi_in
            for (genvar i = 0; i < CAP_GRP_W; i++) begin : g_bit
                assign grp_hi[g][i] = programmed ? (bits_q[HI_BASE + i] ^ invert) : 1'b1;
            end
        end else begin : g_hi_out
            assign grp_hi[g] = {CAP_GRP_W{!programmed}};
        end
    end

endmodule

// File: rtl/epf_cap_masker.sv
// Module epf_cap_masker
// Masks a 64-bit capability word with the permit bits of the selected
// group (lower half) and of the same group's upper bank (upper half).
// The result is registered.
// Assumes: the group permit bits are stable in the request cycle.
module epf_cap_masker
    import epf_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cap_req,
    input  logic                                cap_grp,
    input  logic [CAP_W-1:0]                    cap_in,
    input  logic [CAP_GRPS-1:0][CAP_GRP_W-1:0]  grp_lo,
    input  logic [CAP_GRPS-1:0][CAP_GRP_W-1:0]  grp_hi,
    output logic                                cap_valid,
    output logic [CAP_W-1:0]                    cap_out
);

    logic [CAP_W-1:0] mask;

    // Build the 64-bit mask for the selected group.
    always_comb begin
        mask = {grp_hi[cap_grp], grp_lo[cap_grp]};
    end

    // Register the masked word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_out   <= '0;
        end else begin
            cap_valid <= cap_req;
            if (cap_req) begin
                cap_out <= cap_in & mask;
            end
        end
    end

endmodule

// File: rtl/event_permit_filter.sv
// Module event_permit_filter
// Top of the event permit filter. It ties together the command walker,
// the permit bit store and the capability masker.
// Assumes: EVT_BITS >= 6. HI_BANK is the event offset of the upper
// capability bank.
module event_permit_filter
    import epf_pkg::*;
#(
    parameter int EVT_BITS = 10,
    parameter int HI_BANK  = 16384
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_lock,
    input  logic                cmd_valid,
    input  logic [EVT_BITS:0]   cmd_base,
    input  logic [EVT_BITS:0]   cmd_count,
    input  logic [1:0]          cmd_action,
    output logic                cmd_busy,
    output logic                cmd_done,
    output logic                rsp_bad,
    output logic                rsp_locked,
    input  logic                lk_req,
    input  logic [EVT_BITS-1:0] lk_event,
    output logic                lk_valid,
    output logic                lk_permit,
    input  logic                cap_req,
    input  logic                cap_grp,
    input  logic [63:0]         cap_in,
    output logic                cap_valid,
    output logic [63:0]         cap_out
);

    logic                programmed;
    logic                invert;
    logic                wr_en;
    logic [EVT_BITS-1:0] wr_idx;
    logic                wr_val;
    logic [CAP_GRPS-1:0][CAP_GRP_W-1:0] grp_lo;
    logic [CAP_GRPS-1:0][CAP_GRP_W-1:0] grp_hi;

    epf_cmd_walker #(.EVT_BITS(EVT_BITS)) walker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_lock   (run_lock),
        .cmd_valid  (cmd_valid),
        .cmd_base   (cmd_base),
        .cmd_count  (cmd_count),
        .cmd_action (cmd_action),
        .cmd_busy   (cmd_busy),
        .cmd_done   (cmd_done),
        .rsp_bad    (rsp_bad),
        .rsp_locked (rsp_locked),
        .programmed (programmed),
        .invert     (invert),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_val     (wr_val)
    );

    epf_bit_store #(.EVT_BITS(EVT_BITS), .HI_BANK(HI_BANK)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .programmed (programmed),
        .invert     (invert),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_val     (wr_val),
        .lk_req     (lk_req),
        .lk_event   (lk_event),
        .lk_valid   (lk_valid),
        .lk_permit  (lk_permit),
        .grp_lo     (grp_lo),
        .grp_hi     (grp_hi)
    );

    epf_cap_masker masker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_req   (cap_req),
        .cap_grp   (cap_grp),
        .cap_in    (cap_in),
        .grp_lo    (grp_lo),
        .grp_hi    (grp_hi),
        .cap_valid (cap_valid),
        .cap_out   (cap_out)
    );

endmodule

// File: rtl/event_permit_filter_chk.sv
// Module event_permit_filter_chk
// Protocol checks on the ports of event_permit_filter, bound to every
// instance of it.
// Assumes: synchronous active-low reset.
module event_permit_filter_chk #(
    parameter int EVT_BITS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic run_lock,
    input logic cmd_valid,
    input logic cmd_busy,
    input logic cmd_done,
    input logic rsp_bad,
    input logic rsp_locked,
    input logic lk_req,
    input logic lk_valid,
    input logic cap_req,
    input logic cap_valid
);

    // R7
    lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_locked |-> ($past(run_lock) && $past(cmd_valid)));

    // R5
    reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_bad && rsp_locked));

    // R6
    bad_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad |-> ($past(cmd_valid) && !$past(cmd_busy)));

    // R8
    done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ($past(cmd_busy) && !cmd_busy));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> $past(cmd_valid));

    // R8
    no_reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> (!rsp_bad && !rsp_locked));

    // R9
    lookup_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    // R9
    lookup_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $past(lk_req));

    // R10
    cap_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |=> cap_valid);

endmodule

bind event_permit_filter event_permit_filter_chk #(.EVT_BITS(EVT_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_lock   (run_lock),
    .cmd_valid  (cmd_valid),
    .cmd_busy   (cmd_busy),
    .cmd_done   (cmd_done),
    .rsp_bad    (rsp_bad),
    .rsp_locked (rsp_locked),
    .lk_req     (lk_req),
    .lk_valid   (lk_valid),
    .cap_req    (cap_req),
    .cap_valid  (cap_valid)
);

// File: tb/event_permit_filter_tb_top.sv
// Directed bench for event_permit_filter. Each scenario task checks its
// own results. The event space is widened so that the upper capability
// bank is reachable.
module event_permit_filter_tb_top;

    localparam int EB   = 15;
    localparam int NEVT = 1 << EB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_lock = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [EB:0]   cmd_base = '0;
    logic [EB:0]   cmd_count = '0;
    logic [1:0]    cmd_action = 2'b00;
    logic          cmd_busy, cmd_done, rsp_bad, rsp_locked;
    logic          lk_req = 1'b0;
    logic [EB-1:0] lk_event = '0;
    logic          lk_valid, lk_permit;
    logic          cap_req = 1'b0;
    logic          cap_grp = 1'b0;
    logic [63:0]   cap_in = '0;
    logic          cap_valid;
    logic [63:0]   cap_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    event_permit_filter #(.EVT_BITS(EB), .HI_BANK(16384)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_lock(run_lock),
        .cmd_valid(cmd_valid), .cmd_base(cmd_base), .cmd_count(cmd_count),
        .cmd_action(cmd_action), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .rsp_bad(rsp_bad), .rsp_locked(rsp_locked),
        .lk_req(lk_req), .lk_event(lk_event), .lk_valid(lk_valid),
        .lk_permit(lk_permit), .cap_req(cap_req), .cap_grp(cap_grp),
        .cap_in(cap_in), .cap_valid(cap_valid), .cap_out(cap_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sends one command and reports the accept/reject outcome.
    // Returns cycles of busy (0 if rejected).
    task automatic send_cmd(input int base, input int cnt, input logic [1:0] act,
                            output logic bad, output logic locked, output int busy_cyc,
                            output logic done_seen);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_base   = (EB+1)'(base);
        cmd_count  = (EB+1)'(cnt);
        cmd_action = act;
        @(negedge clk);
        cmd_valid = 1'b0;
        bad       = rsp_bad;
        locked    = rsp_locked;
        busy_cyc  = 0;
        while (cmd_busy) begin
            busy_cyc++;
            @(negedge clk);
        end
        done_seen = cmd_done;
    endtask

    task automatic lookup(input int evt, input logic exp, input string req);
        lk_req   = 1'b1;
        lk_event = EB'(evt);
        @(negedge clk);
        lk_req = 1'b0;
        check({req, " lk_valid"}, 64'(lk_valid), 64'd1);
        check(req, 64'(lk_permit), 64'(exp));
        @(negedge clk);
        check({req, " lk_valid drop"}, 64'(lk_valid), 64'd0);
    endtask

    task automatic cap_query(input logic grp, input logic [63:0] word,
                             input logic [63:0] exp, input string req);
        cap_req = 1'b1;
        cap_grp = grp;
        cap_in  = word;
        @(negedge clk);
        cap_req = 1'b0;
        check({req, " cap_valid"}, 64'(cap_valid), 64'd1);
        check(req, cap_out, exp);
    endtask

    task automatic t_unprogrammed();
        do_reset();
        @(negedge clk);
        check("R1 busy at reset", 64'(cmd_busy), 64'd0);
        lookup(0, 1'b1, "R1 event 0");
        lookup(1023, 1'b1, "R1 event 1023");
        lookup(NEVT - 1, 1'b1, "R1 last event");
        cap_query(1'b0, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, "R1 cap pass");
    endtask

    task automatic t_allow_first();
        logic b, l, d;
        int   cyc;
        send_cmd(10, 4, 2'b01, b, l, cyc, d);
        check("R2 accepted", 64'({b, l}), 64'd0);
        check("R8 busy cycles", 64'(cyc), 64'd5);
        check("R8 done pulse", 64'(d), 64'd1);
        lookup(9, 1'b0, "R2 below range");
        lookup(10, 1'b1, "R2 range start");
        lookup(13, 1'b1, "R2 range end");
        lookup(14, 1'b0, "R2 above range");
        lookup(30000, 1'b0, "R2 far entry");
    endtask

    task automatic t_cap_banks();
        logic b, l, d;
        int   cyc;
        cap_query(1'b0, '1, 64'h0000_0000_0000_3C00, "R10 group0 low");
        send_cmd(16385, 1, 2'b01, b, l, cyc, d);
        cap_query(1'b0, '1, 64'h0000_0002_0000_3C00, "R11 upper bank bit");
        cap_query(1'b0, 64'h0000_0002_0000_0400, 64'h0000_0002_0000_0400, "R11 pattern mask");
        send_cmd(40, 1, 2'b01, b, l, cyc, d);
        cap_query(1'b1, '1, 64'h0000_0000_0000_0100, "R10 group1");
    endtask

    task automatic t_range_err();
        logic b, l, d;
        int   cyc;
        send_cmd(NEVT - 8, 9, 2'b01, b, l, cyc, d);
        check("R5 over range bad", 64'(b), 64'd1);
        check("R5 over range no busy", 64'(cyc), 64'd0);
        lookup(NEVT - 8, 1'b0, "R5 no change");
        send_cmd(NEVT - 1, 1, 2'b01, b, l, cyc, d);
        check("R5 exact end accepted", 64'(b), 64'd0);
        lookup(NEVT - 1, 1'b1, "R5 last entry set");
    endtask

    task automatic t_bad_action();
        logic b, l, d;
        int   cyc;
        send_cmd(0, 2, 2'b11, b, l, cyc, d);
        check("R6 code 11 bad", 64'(b), 64'd1);
        send_cmd(0, 2, 2'b00, b, l, cyc, d);
        check("R6 code 00 bad", 64'(b), 64'd1);
        lookup(0, 1'b0, "R6 entry untouched");
    endtask

    task automatic t_later_deny();
        logic b, l, d;
        int   cyc;
        send_cmd(11, 1, 2'b10, b, l, cyc, d);
        check("R4 deny accepted", 64'(b), 64'd0);
        lookup(11, 1'b0, "R4 cleared entry");
        lookup(10, 1'b1, "R4 neighbour kept");
        lookup(500, 1'b0, "R4 default kept");
    endtask

    task automatic t_locked();
        logic b, l, d;
        int   cyc;
        run_lock = 1'b1;
        send_cmd(0, 1, 2'b01, b, l, cyc, d);
        check("R7 locked flag", 64'(l), 64'd1);
        check("R7 no busy", 64'(cyc), 64'd0);
        lookup(0, 1'b0, "R7 entry untouched");
        send_cmd(NEVT, 1, 2'b01, b, l, cyc, d);
        check("R7 bad range under lock", 64'({b, l}), 64'b10);
        run_lock = 1'b0;
    endtask

    task automatic t_reset_clears();
        do_reset();
        @(negedge clk);
        lookup(11, 1'b1, "R12 entry permitted again");
        lookup(500, 1'b1, "R12 default permitted");
    endtask

    task automatic t_deny_first();
        logic b, l, d;
        int   cyc;
        send_cmd(100, 3, 2'b10, b, l, cyc, d);
        check("R3 busy cycles", 64'(cyc), 64'd4);
        lookup(99, 1'b1, "R3 below range");
        lookup(100, 1'b0, "R3 range start");
        lookup(102, 1'b0, "R3 range end");
        lookup(103, 1'b1, "R3 above range");
        cap_query(1'b1, '1, 64'hFFFF_FFFF_FFFF_FFFF, "R11 deny-default upper");
    endtask

    task automatic t_zero_count();
        logic b, l, d;
        int   cyc;
        do_reset();
        send_cmd(5, 0, 2'b01, b, l, cyc, d);
        check("R13 accepted", 64'(b), 64'd0);
        check("R13 busy one cycle", 64'(cyc), 64'd1);
        check("R13 done", 64'(d), 64'd1);
        lookup(5, 1'b0, "R13 base denied");
        lookup(200, 1'b0, "R13 default denied");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_unprogrammed();
        t_allow_first();
        t_cap_banks();
        t_range_err();
        t_bad_action();
        t_later_deny();
        t_locked();
        t_reset_clears();
        t_deny_first();
        t_zero_count();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule